// File: doc/BRIEF.md
# Burst-Mode DMA Request Sequencer

This block holds the request handling and transfer pacing for a single DMA channel running in burst mode. An external request line goes through a two-stage synchroniser. Depending on a mode input, the block then treats the request either as a level that must stay active or as a rising edge that starts the whole burst. Once a request is accepted, the block waits a fixed number of cycles. It then issues one transfer strobe per data item, with an acknowledge pulse covering each two-cycle transfer. It counts the items down from a programmed total and raises a done flag when the count is used up.

A non-maskable interrupt can suspend the channel. The transfer already on the bus finishes first, and after that the strobe and acknowledge stay quiet. The channel resumes only once the suspend flag has been cleared and a new rising edge on the request line has been seen after the clear. Bus arbitration, address generation and data movement are handled elsewhere. This block only decides when each transfer cycle happens.

Top module: `dma_burst_seq`

## Requirements
- R1: After reset, xferStb, ack and done are all low.
- R2: When enable goes high in the idle state, the counter loads xferCount. A count of zero raises done within four cycles and produces no strobe.
- R3: The first strobe of a burst comes exactly five clock edges after the edge that first captures the new request level at reqIn. That is two synchroniser edges, then three cycles from the sample that accepts the request to the first transfer cycle.
- R4: In level mode (edgeMode = 0), a confirming sample is taken two cycles after the accepting sample. If the request is low at that point, no transfer starts and the channel goes back to waiting.
- R5: In level mode, the request is re-sampled in an idle cycle after each two-cycle transfer. Strobes are therefore three cycles apart while the request stays high, and they stop once the re-sample sees it low.
- R6: In edge mode (edgeMode = 1), a single rising edge starts a burst. Strobes then come every two cycles until the count is exhausted, whatever reqIn does meanwhile.
- R7: ack is high in the strobe cycle and in the following cycle of every transfer, so the number of ack-high cycles is twice the number of strobes.
- R8: When the count reaches zero, done goes high and stays high. No further strobe occurs, even on new requests, until enable is dropped and raised again.
- R9: A pulse on nmiSet sets the suspend flag. A transfer already started completes, and no strobe is issued while the flag is set.
- R10: After a suspend, a rising request edge seen while the flag is still set is discarded. A request held high across the clear does not restart the channel. Only a rising edge after nmiClr resumes the channel, with the R3 latency, and the remaining count is then completed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Channel enable; rising use loads the count, low aborts to idle |
| edgeMode | input | 1 | 0 = level-sensitive request, 1 = edge-sensitive request |
| xferCount | input | CNT_W | Number of items in the burst |
| reqIn | input | 1 | Asynchronous external transfer request |
| nmiSet | input | 1 | Pulse that sets the suspend flag |
| nmiClr | input | 1 | Pulse that clears the suspend flag (set has priority) |
| xferStb | output | 1 | One-cycle strobe at the start of each transfer cycle |
| ack | output | 1 | Acknowledge, high for both cycles of each transfer |
| done | output | 1 | Transfer count exhausted |

## Verification
The hardest situation to reach is the resume rule after a suspend. The bench has to stop an edge-mode burst partway through and then produce a rising request edge while the flag is still set. It also has to leave the request high across the clear. Only after that may it produce a genuine new edge. The stimulus waits for the second strobe at the port, pulses nmiSet in that cycle, then toggles reqIn and pulses nmiClr with the line still high. It confirms that nothing moves for many cycles. It then drops and re-raises the request and checks both the restart latency and that the leftover count completes.

// File: rtl/dma_burst_pkg.sv
package dma_burst_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAIT,
    ST_LAT1,
    ST_LAT2,
    ST_XFER1,
    ST_XFER2,
    ST_GAP,
    ST_HALT,
    ST_DONE
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic load;
    logic dec;
  } dpCtl_t;

  // datapath -> control status
  typedef struct packed {
    logic reqLvl;
    logic reqEdge;
    logic cntZero;
    logic cntLast;
    logic nmiHold;
  } dpStat_t;

endpackage

// File: rtl/dma_burst_dp.sv
module dma_burst_dp
  import dma_burst_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqIn,
  input  logic             nmiSet,
  input  logic             nmiClr,
  input  logic [CNT_W-1:0] xferCount,
  input  dpCtl_t           ctl,
  output dpStat_t          stat,
  output logic             nmiFlag
);

  localparam int SYNC_MSB = SYNC_STAGES - 1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [SYNC_MSB:0] syncQ;
  logic              reqPrev;
  logic [CNT_W-1:0]  cnt;
  logic              flagQ;

  // request synchroniser chain
  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_MSB-1:0], reqIn};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= reqIn;
      end
    end
  endgenerate

  // previous sampled value for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) reqPrev <= 1'b0;
    else       reqPrev <= syncQ[SYNC_MSB];
  end

  // transfer counter
  always_ff @(posedge clk) begin
    if (!rstN)                     cnt <= '0;
    else if (ctl.load)             cnt <= xferCount;
    else if (ctl.dec && cnt != '0) cnt <= cnt - CNT_ONE;
  end

  // suspend flag, set wins over clear
  always_ff @(posedge clk) begin
    if (!rstN)       flagQ <= 1'b0;
    else if (nmiSet) flagQ <= 1'b1;
    else if (nmiClr) flagQ <= 1'b0;
  end

  assign nmiFlag = flagQ;

  always_comb begin
    stat.reqLvl  = syncQ[SYNC_MSB];
    stat.reqEdge = syncQ[SYNC_MSB] & ~reqPrev;
    stat.cntZero = (cnt == '0);
    stat.cntLast = (cnt == CNT_ONE);
    stat.nmiHold = flagQ | nmiSet;
  end

endmodule

// File: rtl/dma_burst_ctl.sv
module dma_burst_ctl
  import dma_burst_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    edgeMode,
  input  dpStat_t stat,
  output dpCtl_t  ctl,
  output logic    xferStb,
  output logic    ack,
  output logic    done
);

  seqState_t state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt      = state;
    ctl.load = 1'b0;
    ctl.dec  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (enable) begin
          ctl.load = 1'b1;
          nxt      = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (stat.cntZero)                                nxt = ST_DONE;
        else if (stat.nmiHold)                           nxt = ST_HALT;
        else if (edgeMode ? stat.reqEdge : stat.reqLvl)  nxt = ST_LAT1;
      end
      ST_LAT1: begin
        nxt = stat.nmiHold ? ST_HALT : ST_LAT2;
      end
      ST_LAT2: begin
        if (stat.nmiHold)                   nxt = ST_HALT;
        else if (!edgeMode && !stat.reqLvl) nxt = ST_WAIT;
        else                                nxt = ST_XFER1;
      end
      ST_XFER1: nxt = ST_XFER2;
      ST_XFER2: begin
        ctl.dec = 1'b1;
        if (stat.cntLast)      nxt = ST_DONE;
        else if (stat.nmiHold) nxt = ST_HALT;
        else if (edgeMode)     nxt = ST_XFER1;
        else                   nxt = ST_GAP;
      end
      ST_GAP: begin
        if (stat.nmiHold)     nxt = ST_HALT;
        else if (stat.reqLvl) nxt = ST_XFER1;
        else                  nxt = ST_WAIT;
      end
      ST_HALT: begin
        if (!stat.nmiHold && stat.reqEdge) nxt = ST_LAT1;
      end
      ST_DONE: nxt = ST_DONE;
      default: nxt = ST_IDLE;
    endcase
    if (!enable) begin
      nxt      = ST_IDLE;
      ctl.load = 1'b0;
    end
  end

  assign xferStb = (state == ST_XFER1);
  assign ack     = (state == ST_XFER1) || (state == ST_XFER2);
  assign done    = (state == ST_DONE);

endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq
  import dma_burst_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             edgeMode,
  input  logic [CNT_W-1:0] xferCount,
  input  logic             reqIn,
  input  logic             nmiSet,
  input  logic             nmiClr,
  output logic             xferStb,
  output logic             ack,
  output logic             done
);

  dpCtl_t  ctl;
  dpStat_t stat;
  logic    nmiFlag;

  dma_burst_dp #(
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .reqIn    (reqIn),
    .nmiSet   (nmiSet),
    .nmiClr   (nmiClr),
    .xferCount(xferCount),
    .ctl      (ctl),
    .stat     (stat),
    .nmiFlag  (nmiFlag)
  );

  dma_burst_ctl u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .edgeMode(edgeMode),
    .stat    (stat),
    .ctl     (ctl),
    .xferStb (xferStb),
    .ack     (ack),
    .done    (done)
  );

endmodule

// File: rtl/dma_burst_chk.sv
module dma_burst_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic xferStb,
  input logic ack,
  input logic done,
  input logic nmiFlag
);

  // R7: strobe cycle is covered by acknowledge
  a_r7_stb_has_ack: assert property (@(posedge clk) disable iff (!rstN)
    xferStb |-> ack);

  // R7: acknowledge spans a second cycle with no new strobe
  a_r7_ack_two_cycles: assert property (@(posedge clk) disable iff (!rstN)
    (xferStb && enable) |=> (ack && !xferStb));

  // R9: no new transfer while suspended
  a_r9_nmi_quiet: assert property (@(posedge clk) disable iff (!rstN)
    nmiFlag |-> !xferStb);

  // R8: done is sticky while enabled and silences the bus
  a_r8_done_holds: assert property (@(posedge clk) disable iff (!rstN)
    (done && enable) |=> (done && !ack));

  // R8: done and acknowledge are exclusive
  a_r8_done_no_ack: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !ack);

endmodule

bind dma_burst_seq dma_burst_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .enable (enable),
  .xferStb(xferStb),
  .ack    (ack),
  .done   (done),
  .nmiFlag(nmiFlag)
);

// File: tb/dma_burst_seq_tb.sv
module dma_burst_seq_tb;

  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             enable = 1'b0;
  logic             edgeMode = 1'b0;
  logic [CNT_W-1:0] xferCount = '0;
  logic             reqIn = 1'b0;
  logic             nmiSet = 1'b0;
  logic             nmiClr = 1'b0;
  logic             xferStb, ack, done;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;

  // monitor state (cleared by tasks only while the bus is quiet)
  int stbCnt = 0, ackCnt = 0;
  int firstCyc = -1, lastCyc = -1;
  int minGap = 1000, maxGap = 0;

  dma_burst_seq #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .edgeMode(edgeMode),
    .xferCount(xferCount), .reqIn(reqIn), .nmiSet(nmiSet), .nmiClr(nmiClr),
    .xferStb(xferStb), .ack(ack), .done(done)
  );

  always #10 clk = ~clk;   // 50 MHz

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (ack) ackCnt = ackCnt + 1;
    if (xferStb) begin
      stbCnt = stbCnt + 1;
      if (firstCyc < 0) firstCyc = cyc;
      else begin
        if (cyc - lastCyc < minGap) minGap = cyc - lastCyc;
        if (cyc - lastCyc > maxGap) maxGap = cyc - lastCyc;
      end
      lastCyc = cyc;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic checkEq(input string tag, input int act, input int exp);
    check(act == exp, tag, act, exp);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clrMon();
    stbCnt = 0; ackCnt = 0; firstCyc = -1; lastCyc = -1;
    minGap = 1000; maxGap = 0;
  endtask

  task automatic startChan(input bit mode, input int count);
    reqIn = 1'b0;
    enable = 1'b0;
    step(4);
    edgeMode = mode;
    xferCount = CNT_W'(count);
    enable = 1'b1;
    step(3);
    clrMon();
  endtask

  task automatic waitStrobes(input int n);
    int seen = 0;
    while (seen < n) begin
      step(1);
      if (xferStb) seen++;
    end
  endtask

  task automatic testReset();
    step(1);
    checkEq("R1 xferStb after reset", xferStb, 0);
    checkEq("R1 ack after reset", ack, 0);
    checkEq("R1 done after reset", done, 0);
  endtask

  task automatic testZeroCount();
    startChan(1'b0, 0);
    reqIn = 1'b1;
    step(12);
    checkEq("R2 zero count done", done, 1);
    checkEq("R2 zero count strobes", stbCnt, 0);
  endtask

  task automatic testLevelFull();
    int rc;
    startChan(1'b0, 5);
    reqIn = 1'b1; rc = cyc;
    step(30);
    checkEq("R3 level latency", firstCyc - rc, 5);
    checkEq("R5 level strobes", stbCnt, 5);
    checkEq("R5 level min gap", minGap, 3);
    checkEq("R5 level max gap", maxGap, 3);
    checkEq("R7 level ack cycles", ackCnt, 10);
    checkEq("R8 level done", done, 1);
  endtask

  task automatic testLevelConfirm();
    startChan(1'b0, 3);
    reqIn = 1'b1;
    step(1);
    reqIn = 1'b0;
    step(20);
    checkEq("R4 short pulse strobes", stbCnt, 0);
    checkEq("R4 short pulse done", done, 0);
  endtask

  task automatic testLevelDrop();
    int rc;
    startChan(1'b0, 8);
    reqIn = 1'b1;
    waitStrobes(3);
    reqIn = 1'b0;
    step(20);
    checkEq("R5 level stop strobes", stbCnt, 3);
    checkEq("R5 level stop done", done, 0);
    clrMon();
    reqIn = 1'b1; rc = cyc;
    step(30);
    checkEq("R3 level relaunch latency", firstCyc - rc, 5);
    checkEq("R5 level remaining strobes", stbCnt, 5);
    checkEq("R8 level relaunch done", done, 1);
  endtask

  task automatic testEdgeBurst();
    int rc;
    startChan(1'b1, 4);
    reqIn = 1'b1; rc = cyc;
    waitStrobes(1);
    reqIn = 1'b0;
    step(2);
    reqIn = 1'b1;
    step(2);
    reqIn = 1'b0;
    step(20);
    checkEq("R3 edge latency", firstCyc - rc, 5);
    checkEq("R6 edge strobes", stbCnt, 4);
    checkEq("R6 edge min gap", minGap, 2);
    checkEq("R6 edge max gap", maxGap, 2);
    checkEq("R7 edge ack cycles", ackCnt, 8);
    checkEq("R8 edge done", done, 1);
    // new edge after done must do nothing
    reqIn = 1'b1;
    step(20);
    checkEq("R8 edge after done strobes", stbCnt, 4);
    checkEq("R8 done sticky", done, 1);
    // re-enable restores operation
    startChan(1'b1, 2);
    reqIn = 1'b1;
    step(20);
    checkEq("R8 re-enable strobes", stbCnt, 2);
    checkEq("R8 re-enable done", done, 1);
  endtask

  task automatic testNmi();
    int rc;
    startChan(1'b1, 6);
    reqIn = 1'b1;
    waitStrobes(2);
    nmiSet = 1'b1;
    step(1);
    nmiSet = 1'b0;
    step(10);
    checkEq("R9 strobes before halt", stbCnt, 2);
    checkEq("R9 ack cycles before halt", ackCnt, 4);
    checkEq("R9 ack low while held", ack, 0);
    // edge while flag still set: discarded
    reqIn = 1'b0;
    step(4);
    reqIn = 1'b1;
    step(6);
    nmiClr = 1'b1;
    step(1);
    nmiClr = 1'b0;
    step(20);
    checkEq("R10 no restart without fresh edge", stbCnt, 2);
    checkEq("R10 no done while held", done, 0);
    // fresh edge after clear
    reqIn = 1'b0;
    step(4);
    clrMon();
    reqIn = 1'b1; rc = cyc;
    step(20);
    checkEq("R10 resume latency", firstCyc - rc, 5);
    checkEq("R10 remaining strobes", stbCnt, 4);
    checkEq("R10 done after resume", done, 1);
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    testReset();
    testZeroCount();
    testLevelFull();
    testLevelConfirm();
    testLevelDrop();
    testEdgeBurst();
    testNmi();
    step(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #2000000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule